// File: doc/BRIEF.md
# Colour Palette Store with Dimmed Shadow Table

This block holds a 32-colour palette that software loads through a window of even register offsets inside a wider register space. Every accepted write lands in two places. The first is a linear table indexed by the entry number. The second is a 64-entry pixel table in which the entry number is bit-reversed. In the same cycle the hardware also fills the pixel-table slot 32 above that position with a dimmed copy of the colour, so a display pipeline can use a 6-bit pixel code in which bit 5 selects half brightness.

Colours are 16-bit words made of 4-bit components. The dimmed copy shifts each component right by one place, and no bit carries across a component boundary. Two synchronous read ports are provided. The linear port takes a 5-bit entry number and the pixel port takes a 6-bit code. Each returns its word on the clock after the index is presented.

Top module: `pal_shadow_ram`

## Requirements
- R1: While reset is high, and on the first clock after it, both read outputs are zero.
- R2: A write with `wr_en` high to an even offset from 0x180 to 0x1be stores `wr_data` in the linear table at entry (offset − 0x180)/2, and `lin_data` shows that word one clock after `lin_idx` selects the entry.
- R3: Writes to odd offsets, or to offsets below 0x180 or above 0x1be, change neither table.
- R4: An accepted write to entry k also stores `wr_data` in the pixel table at code {0, reverse(k)}, where reverse swaps bit i of the 5-bit entry number with bit 4−i.
- R5: The same write stores the dimmed word (wr_data >> 1) & 0x7777 at pixel code {1, reverse(k)}.
- R6: `pix_data` and `lin_data` each show the entry selected on the previous clock, with one clock of latency, for any sequence of indices.
- R7: A read and a write to the same entry on the same clock return the word held before the write. The new word is visible from the next read.
- R8: With `wr_en` low, the offset and data inputs have no effect on either table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_off | input | 9 | Register byte offset of the write |
| wr_data | input | 16 | Colour word written |
| lin_idx | input | 5 | Linear table read index |
| lin_data | output | 16 | Linear table word, one clock after index |
| pix_idx | input | 6 | Pixel code: bit 5 selects the dimmed half |
| pix_data | output | 16 | Pixel table word, one clock after code |

## Verification
A full load of all 32 entries with distinct words, followed by sweeps of both halves of the pixel table, separates a correct bit reversal from an identity or partial permutation and exposes any carry between components in the dimmed copy. Writes at odd offsets, at the two offsets just outside the window and with the strobe low tell correct decoding apart from a decoder that is too loose. A same-entry read and write in one cycle separates read-before-write behaviour from write-through. A long pseudo-random mix of in-window and out-of-window writes with changing read indices checks the latency under back-to-back traffic.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned DEF_OFF_W   = 9;
  localparam int unsigned DEF_BASE    = 'h180;
  localparam int unsigned DEF_ENTRIES = 32;
  localparam int unsigned DEF_DATA_W  = 16;
  localparam int unsigned DEF_COMP_W  = 4;
endpackage

// File: rtl/pal_decode.sv
module pal_decode #(
  parameter int unsigned OFF_W   = 9,
  parameter int unsigned BASE    = 'h180,
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  localparam logic [OFF_W:0] LO = (OFF_W+1)'(BASE);
  localparam logic [OFF_W:0] HI = (OFF_W+1)'(BASE + 2*ENTRIES);

  logic [OFF_W:0] ext;
  logic [OFF_W:0] rel;

  always_comb begin
    ext = {1'b0, wr_off};
    rel = ext - LO;
    hit = wr_en && !wr_off[0] && (ext >= LO) && (ext < HI);
    idx = IDX_W'(rel >> 1);
  end
endmodule

// File: rtl/pal_permute.sv
module pal_permute #(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] idx_in,
  output logic [IDX_W-1:0] idx_out
);
  for (genvar b = 0; b < IDX_W; b++) begin : g_rev
    assign idx_out[b] = idx_in[IDX_W-1-b];
  end
endmodule

// File: rtl/pal_halfbright.sv
module pal_halfbright #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COMP_W = 4
) (
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int unsigned NCOMP = DATA_W / COMP_W;
  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    assign dout[c*COMP_W +: COMP_W] = {1'b0, din[c*COMP_W+1 +: COMP_W-1]};
  end
endmodule

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/pal_shadow_ram.sv
module pal_shadow_ram #(
  parameter int unsigned OFF_W   = pal_pkg::DEF_OFF_W,
  parameter int unsigned BASE    = pal_pkg::DEF_BASE,
  parameter int unsigned ENTRIES = pal_pkg::DEF_ENTRIES,
  parameter int unsigned DATA_W  = pal_pkg::DEF_DATA_W,
  parameter int unsigned COMP_W  = pal_pkg::DEF_COMP_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  lin_idx,
  output logic [DATA_W-1:0] lin_data,
  input  logic [IDX_W:0]    pix_idx,
  output logic [DATA_W-1:0] pix_data
);
  logic              hit;
  logic [IDX_W-1:0]  widx;
  logic [IDX_W-1:0]  pidx;
  logic [DATA_W-1:0] dim;
  logic [DATA_W-1:0] full_q;
  logic [DATA_W-1:0] dim_q;
  logic              half_q;

  pal_decode #(.OFF_W(OFF_W), .BASE(BASE), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_dec (
    .wr_en(wr_en), .wr_off(wr_off), .hit(hit), .idx(widx)
  );

  pal_permute #(.IDX_W(IDX_W)) u_perm (.idx_in(widx), .idx_out(pidx));

  pal_halfbright #(.DATA_W(DATA_W), .COMP_W(COMP_W)) u_dim (.din(wr_data), .dout(dim));

  pal_ram #(.DATA_W(DATA_W), .DEPTH(ENTRIES), .AW(IDX_W)) u_lin (
    .clk(clk), .rst(rst), .we(hit), .waddr(widx), .wdata(wr_data),
    .raddr(lin_idx), .rdata(lin_data)
  );

  pal_ram #(.DATA_W(DATA_W), .DEPTH(ENTRIES), .AW(IDX_W)) u_full (
    .clk(clk), .rst(rst), .we(hit), .waddr(pidx), .wdata(wr_data),
    .raddr(pix_idx[IDX_W-1:0]), .rdata(full_q)
  );

  pal_ram #(.DATA_W(DATA_W), .DEPTH(ENTRIES), .AW(IDX_W)) u_half (
    .clk(clk), .rst(rst), .we(hit), .waddr(pidx), .wdata(dim),
    .raddr(pix_idx[IDX_W-1:0]), .rdata(dim_q)
  );

  always_ff @(posedge clk) begin
    if (rst) half_q <= 1'b0;
    else     half_q <= pix_idx[IDX_W];
  end

  assign pix_data = half_q ? dim_q : full_q;
endmodule

// File: rtl/pal_shadow_chk.sv
module pal_shadow_chk #(
  parameter int unsigned OFF_W   = 9,
  parameter int unsigned BASE    = 'h180,
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned COMP_W  = 4,
  parameter int unsigned IDX_W   = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [OFF_W-1:0]  wr_off,
  input logic [DATA_W-1:0] wr_data,
  input logic [IDX_W-1:0]  lin_idx,
  input logic [DATA_W-1:0] lin_data,
  input logic [IDX_W:0]    pix_idx,
  input logic [DATA_W-1:0] pix_data
);
  function automatic logic [IDX_W-1:0] flip(input logic [IDX_W-1:0] v);
    logic [IDX_W-1:0] r;
    for (int i = 0; i < IDX_W; i++) r[i] = v[IDX_W-1-i];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] halve(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++)
      r[i] = ((i % COMP_W) == COMP_W-1) ? 1'b0 : v[i+1];
    return r;
  endfunction

  logic             was_rst = 1'b0;
  logic [1:0]       age = 2'd0;
  logic             acc;
  logic [IDX_W-1:0] ent;
  int unsigned      offv;

  always_comb begin
    offv = int'(wr_off);
    acc  = wr_en && (offv % 2 == 0) && (offv >= BASE) && (offv < BASE + 2*ENTRIES);
    ent  = IDX_W'((offv - BASE) / 2);
  end

  always_ff @(posedge clk) begin
    was_rst <= rst;
    if (rst) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    was_rst |-> (pix_data == '0 && lin_data == '0));

  // R2
  lin_store_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(acc, 2) && !$past(acc) && $past(lin_idx) == $past(ent, 2))
    |-> lin_data == $past(wr_data, 2));

  // R4
  pix_full_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(acc, 2) && !$past(acc) && $past(pix_idx) == {1'b0, flip($past(ent, 2))})
    |-> pix_data == $past(wr_data, 2));

  // R5
  pix_dim_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(acc, 2) && !$past(acc) && $past(pix_idx) == {1'b1, flip($past(ent, 2))})
    |-> pix_data == halve($past(wr_data, 2)));
endmodule

bind pal_shadow_ram pal_shadow_chk #(
  .OFF_W(OFF_W), .BASE(BASE), .ENTRIES(ENTRIES), .DATA_W(DATA_W), .COMP_W(COMP_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
  .lin_idx(lin_idx), .lin_data(lin_data), .pix_idx(pix_idx), .pix_data(pix_data)
);

// File: tb/sim_pal_shadow_ram.sv
`timescale 1ns/1ps
module sim_pal_shadow_ram;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [8:0]  wr_off = '0;
  logic [15:0] wr_data = '0;
  logic [4:0]  lin_idx = '0;
  logic [15:0] lin_data;
  logic [5:0]  pix_idx = '0;
  logic [15:0] pix_data;

  always #5 clk = ~clk;

  pal_shadow_ram u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .lin_idx(lin_idx), .lin_data(lin_data), .pix_idx(pix_idx), .pix_data(pix_data)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string phase  = "R1";

  logic [15:0] lin_m [32];
  bit          lin_v [32];
  logic [15:0] pix_m [64];
  bit          pix_v [64];
  logic [15:0] exp_lin, exp_pix;
  bit          ok_lin = 0, ok_pix = 0;

  function automatic int flip5(input int v);
    int r = 0;
    for (int i = 0; i < 5; i++) if (v & (1 << i)) r |= 1 << (4 - i);
    return r;
  endfunction

  initial begin
    for (int i = 0; i < 32; i++) lin_v[i] = 0;
    for (int i = 0; i < 64; i++) pix_v[i] = 0;
  end

  // Behavioural reference: read old contents, then apply the write.
  always @(posedge clk) begin : model
    int k, r, o;
    if (rst) begin
      exp_lin <= '0; exp_pix <= '0; ok_lin <= 1; ok_pix <= 1;
    end else begin
      exp_lin <= lin_m[lin_idx]; ok_lin <= lin_v[lin_idx];
      exp_pix <= pix_m[pix_idx]; ok_pix <= pix_v[pix_idx];
      o = int'(wr_off);
      if (wr_en && (o % 2 == 0) && o >= 384 && o <= 446) begin
        k = (o - 384) / 2;
        r = flip5(k);
        lin_m[k] = wr_data; lin_v[k] = 1;
        pix_m[r] = wr_data; pix_v[r] = 1;
        pix_m[r + 32] = (wr_data >> 1) & 16'h7777; pix_v[r + 32] = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      if (ok_lin) begin
        checks++;
        if (lin_data !== exp_lin) begin
          fails++;
          $display("FAIL %s linear port: actual %h expected %h", phase, lin_data, exp_lin);
        end
      end
      if (ok_pix) begin
        checks++;
        if (pix_data !== exp_pix) begin
          fails++;
          $display("FAIL %s pixel port: actual %h expected %h", phase, pix_data, exp_pix);
        end
      end
    end
  end

  task automatic cyc(input logic we, input int off, input logic [15:0] d,
                     input int li, input int pi);
    @(posedge clk); #2;
    wr_en = we; wr_off = 9'(off); wr_data = d; lin_idx = 5'(li); pix_idx = 6'(pi);
  endtask

  initial begin
    logic [15:0] lf = 16'hACE1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (pix_data !== 16'h0 || lin_data !== 16'h0) begin
      fails++;
      $display("FAIL R1 reset outputs: actual %h/%h expected 0000/0000", pix_data, lin_data);
    end
    #2 rst = 1'b0;

    phase = "R2";
    for (int k = 0; k < 32; k++)
      cyc(1, 384 + 2*k, 16'(16'h9E37 * (k + 1)) ^ 16'h5A5A, (k + 31) % 32, (k * 7) % 64);
    cyc(0, 0, 0, 0, 0);

    phase = "R4";
    for (int p = 0; p < 32; p++) cyc(0, 0, 0, p, p);
    phase = "R5";
    for (int p = 32; p < 64; p++) cyc(0, 0, 0, 63 - p, p);

    phase = "R5";
    cyc(1, 384 + 2*5, 16'hFFFF, 5, 0);
    cyc(0, 0, 0, 5, 32 + flip5(5));
    cyc(0, 0, 0, 5, flip5(5));
    cyc(0, 0, 0, 5, flip5(5));

    phase = "R3";
    cyc(1, 'h17e, 16'h1111, 31, 31);
    cyc(1, 'h1c0, 16'h2222, 31, 63);
    cyc(1, 'h181, 16'h3333, 0, 0);
    cyc(1, 'h1bf, 16'h4444, 0, 32);
    for (int p = 0; p < 32; p++) cyc(0, 0, 0, p, 2*p);

    phase = "R8";
    cyc(0, 'h180, 16'hDEAD, 0, 0);
    cyc(0, 'h1be, 16'hBEEF, 0, 31);
    cyc(0, 0, 0, 31, 63);
    cyc(0, 0, 0, 0, 32);

    phase = "R7";
    cyc(1, 'h182, 16'h7C3A, 1, flip5(1));
    cyc(0, 0, 0, 1, flip5(1));
    cyc(1, 'h182, 16'h0F0F, 1, 32 + flip5(1));
    cyc(0, 0, 0, 1, 32 + flip5(1));
    cyc(0, 0, 0, 0, 0);

    phase = "R6";
    for (int n = 0; n < 3000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0], 'h170 + (int'(lf[15:8]) % 'h60), lf ^ 16'h3C96,
          int'(lf[4:0]), int'(lf[10:5]));
    end
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    @(posedge clk); #1;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule